// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a multi-channel sampling converter with four sample paths. Each path can take its input from one of two banks, and one configuration register chooses the bank and how many paths take part in a sequence. A rising edge on the start input captures the selected bank's values on every path in the same clock cycle. The paths are then converted one after another, beginning at path 1, in fixed-length conversion slots. Each 12-bit result goes into a small result memory.

When the last selected path has been converted, an active-low interrupt line goes low. The host then drains the results with read strobes, one result per strobe, in path order. The first read after completion releases the interrupt. The analog front end is represented by a flat input bus of codes. A behavioural successive-approximation stub resolves each held code, one bit per clock, inside a slot of fixed length.

Top module: `simsamp_seq`

## Requirements
- R1: After reset, `busy` is 0, `irq_n` is 1, `rd_valid` is 0, `rd_data` is 0, and the configuration word is 0 (one path, bank A, running).
- R2: The configuration word is laid out as follows. Bits [1:0] hold the path count minus one. Bit 2 selects the bank (0 = bank A, 1 = bank B). Bit 3 is power-down. Path p of bank A reads `ain[p*12 +: 12]`, and path p of bank B reads `ain[(4+p)*12 +: 12]`, with p counted from 0.
- R3: A rising edge of `start`, seen while idle and not powered down, captures every path of the selected bank at that one clock edge. Later changes on `ain` do not alter the results. A `start` level held high does not launch again.
- R4: `busy` rises at the launching edge k. `busy` falls and `irq_n` falls at edge k + 32·N, where N is the number of selected paths. A launch drives `irq_n` high.
- R5: Each stored result equals the code captured for its path.
- R6: `irq_n` stays low after completion until the first read strobe, and it returns high at the edge that takes that strobe.
- R7: A new launch resets the read pointer to path 1.
- R8: A read strobe returns the entry at the pointer in the cycle after the strobe, with `rd_valid` high. After the last converted path, the pointer wraps to path 1.
- R9: A `start` edge while `busy` is ignored: the running sequence keeps its timing and results.
- R10: While power-down is set, no `start` edge launches a sequence: `busy` stays 0 and `irq_n` is unchanged.
- R11: A configuration write during a sequence does not change that sequence's path count, bank or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration word (count−1, bank, power-down) |
| start | input | 1 | Start input; its rising edge launches a sequence |
| ain | input | 96 | Input codes, eight 12-bit lanes: bank A lanes 0–3, bank B lanes 4–7 |
| rd_req | input | 1 | Read strobe, one cycle per result |
| rd_data | output | 12 | Result returned for the last read strobe |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| busy | output | 1 | Sequence in progress |
| irq_n | output | 1 | Active-low completion flag |

## Verification
All timing is counted from the clock edge that first sees `start` high; call it edge k. `busy` is due in the cycle after edge k. Completion, with `busy` and `irq_n` both low, is due exactly after edge k + 32·N. The bench therefore checks that both are still high after edge k + 32·N − 1 and that both are low one edge later. Read data and `rd_valid` are due one edge after the strobe and are sampled on the following falling edge. The interrupt release is checked in that same cycle.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int unsigned cfg_width(input int unsigned npath);
    return $clog2(npath) + 2;
  endfunction

endpackage

// File: rtl/simsamp_conv_stub.sv
module simsamp_conv_stub #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] sample,
  output logic              done,
  output logic [DATA_W-1:0] code
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] held_q;
  logic [DATA_W-1:0] trial_q;
  logic [DATA_W-1:0] step_bit;
  logic [DATA_W-1:0] test_val;

  // one trial bit per clock, MSB first; zero once all bits are resolved
  assign step_bit = {1'b1, {(DATA_W-1){1'b0}}} >> cnt_q;
  assign test_val = trial_q | step_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      held_q   <= '0;
      trial_q  <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      held_q   <= sample;
      trial_q  <= '0;
    end else if (active_q) begin
      if (cnt_q == CNT_LAST) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (test_val <= held_q) begin
        trial_q <= test_val;
      end
    end
  end

  assign done = active_q && (cnt_q == CNT_LAST);
  assign code = trial_q;

  // R5: the search must have settled on the held code by the end of the slot
  p_sar_exact_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (code == held_q));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> !done);

endmodule

// File: rtl/simsamp_rbuf.sv
module simsamp_rbuf #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned NPATH  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(NPATH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     clr,
  input  logic [$clog2(NPATH)-1:0] last_idx,
  input  logic                     rd_req,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);
  localparam int unsigned PTR_W = $clog2(NPATH);

  logic [DATA_W-1:0] mem [NPATH];
  logic [PTR_W-1:0]  ptr_q;

  // plain synchronous write port, no reset, so block RAM fits
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_data <= mem[ptr_q];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q <= '0;
    end else if (rd_req) begin
      ptr_q <= (ptr_q == last_idx) ? '0 : ptr_q + 1'b1;
    end
  end

  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !clr && ptr_q == last_idx) |=> (ptr_q == '0));

  p_ptr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr_q == '0));

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

endmodule

// File: rtl/simsamp_ctrl.sv
module simsamp_ctrl
  import simsamp_pkg::*;
#(
  parameter int unsigned NPATH = 4,
  parameter int unsigned CFG_W = $clog2(NPATH) + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     start,
  input  logic                     done,
  input  logic                     rd_req,
  output logic                     launch,
  output logic                     go,
  output logic                     res_we,
  output logic [$clog2(NPATH)-1:0] slot,
  output logic [$clog2(NPATH)-1:0] seq_last,
  output logic                     bank_sel,
  output logic                     busy,
  output logic                     irq_n
);
  localparam int unsigned MODE_W = $clog2(NPATH);

  logic [CFG_W-1:0]  cfg_q;
  logic              start_q;
  logic              start_edge;
  logic              cfg_pd;
  logic [MODE_W-1:0] cfg_mode;
  logic              last_slot;
  logic              finish;
  seq_state_e        state_q;

  assign cfg_mode = cfg_q[MODE_W-1:0];
  assign bank_sel = cfg_q[MODE_W];
  assign cfg_pd   = cfg_q[MODE_W+1];
  assign busy     = (state_q == SEQ_RUN);

  assign start_edge = start && !start_q;
  assign launch     = start_edge && !busy && !cfg_pd;
  assign last_slot  = (slot == seq_last);
  assign res_we     = busy && done;
  assign finish     = res_we && last_slot;
  assign go         = launch || (res_we && !last_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= start;
      if (cfg_we) begin
        cfg_q <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      slot     <= '0;
      seq_last <= '0;
      irq_n    <= 1'b1;
    end else if (launch) begin
      state_q  <= SEQ_RUN;
      slot     <= '0;
      seq_last <= cfg_mode;
      irq_n    <= 1'b1;
    end else if (res_we) begin
      if (last_slot) begin
        state_q <= SEQ_IDLE;
        irq_n   <= 1'b0;
      end else begin
        slot <= slot + 1'b1;
      end
    end else if (!irq_n && rd_req) begin
      irq_n <= 1'b1;
    end
  end

  p_launch_busy_r4: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy && irq_n));

  p_finish_flag_r4: assert property (@(posedge clk) disable iff (rst)
    finish |=> (!busy && !irq_n));

  // R9, R11: nothing but a slot completion moves a running sequence
  p_run_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && $stable(slot) && $stable(seq_last)));

  p_pd_block_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && cfg_pd) |=> !busy);

  p_irq_release_r6: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && rd_req) |=> irq_n);

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !rd_req && !launch) |=> !irq_n);

endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned NPATH       = 4,
  parameter int unsigned CONV_CYCLES = 32,
  parameter int unsigned CFG_W       = $clog2(NPATH) + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [CFG_W-1:0]          cfg_wdata,
  input  logic                      start,
  input  logic [2*NPATH*DATA_W-1:0] ain,
  input  logic                      rd_req,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_valid,
  output logic                      busy,
  output logic                      irq_n
);
  localparam int unsigned PTR_W = $clog2(NPATH);

  logic              launch;
  logic              go;
  logic              res_we;
  logic              done;
  logic              bank_sel;
  logic [PTR_W-1:0]  slot;
  logic [PTR_W-1:0]  seq_last;
  logic [PTR_W-1:0]  next_idx;
  logic [DATA_W-1:0] conv_code;
  logic [DATA_W-1:0] conv_sample;
  logic [DATA_W-1:0] live  [NPATH];
  logic [DATA_W-1:0] hold_q[NPATH];

  // sample-and-hold: every path of the chosen bank loads on the same edge
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    assign live[p] = bank_sel ? ain[(NPATH+p)*DATA_W +: DATA_W]
                              : ain[p*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q[p] <= '0;
      end else if (launch) begin
        hold_q[p] <= live[p];
      end
    end
  end

  assign next_idx    = PTR_W'(slot + 1'b1);
  assign conv_sample = launch ? live[0] : hold_q[next_idx];

  simsamp_ctrl #(
    .NPATH(NPATH),
    .CFG_W(CFG_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .start    (start),
    .done     (done),
    .rd_req   (rd_req),
    .launch   (launch),
    .go       (go),
    .res_we   (res_we),
    .slot     (slot),
    .seq_last (seq_last),
    .bank_sel (bank_sel),
    .busy     (busy),
    .irq_n    (irq_n)
  );

  simsamp_conv_stub #(
    .DATA_W     (DATA_W),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_conv (
    .clk   (clk),
    .rst   (rst),
    .go    (go),
    .sample(conv_sample),
    .done  (done),
    .code  (conv_code)
  );

  simsamp_rbuf #(
    .DATA_W(DATA_W),
    .NPATH (NPATH)
  ) u_rbuf (
    .clk     (clk),
    .rst     (rst),
    .we      (res_we),
    .waddr   (slot),
    .wdata   (conv_code),
    .clr     (launch),
    .last_idx(seq_last),
    .rd_req  (rd_req),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  // R3: held samples change only at a launch
  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !launch) |=> $stable(hold_q[0]));

endmodule

// File: tb/test_simsamp_seq.sv
module test_simsamp_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        start = 1'b0;
  logic [95:0] ain = '0;
  logic        rd_req = 1'b0;
  logic [11:0] rd_data;
  logic        rd_valid;
  logic        busy;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  simsamp_seq i_simsamp_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start(start), .ain(ain), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .irq_n(irq_n)
  );

  function automatic logic [11:0] gen(input int seed, input int lane);
    return 12'((seed * 733 + lane * 1291 + 17) % 4096);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ain(input int seed);
    for (int i = 0; i < 8; i++) ain[i*12 +: 12] = gen(seed, i);
  endtask

  task automatic write_cfg(input logic [3:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic read_chk(input int exp, input string req);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk({req, " rd_valid"}, int'(rd_valid), 1);
    chk({req, " rd_data"}, int'(rd_data), exp);
  endtask

  // launch, disturb inputs, and check completion lands on edge k + 32*n
  task automatic run_seq(input int n, input int seed, input bit poke,
                         input bit mid_cfg, input logic [3:0] mid_val);
    set_ain(seed);
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    set_ain(seed + 99);
    chk("R4 busy after launch", int'(busy), 1);
    chk("R4 irq_n after launch", int'(irq_n), 1);
    for (int i = 1; i < 32 * n; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (i == 5) start = 1'b0;
      if (poke && i == 20) start = 1'b1;
      if (poke && i == 25) start = 1'b0;
      if (mid_cfg && i == 10) begin cfg_we = 1'b1; cfg_wdata = mid_val; end
    end
    chk("R4 busy before end", int'(busy), 1);
    chk("R4 irq_n before end", int'(irq_n), 1);
    @(negedge clk);
    chk("R4 busy at end", int'(busy), 0);
    chk("R4 irq_n at end", int'(irq_n), 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_data", int'(rd_data), 0);
  endtask

  task automatic t_four_bank_a;
    write_cfg(4'b0011);
    run_seq(4, 1, 1'b0, 1'b0, 4'h0);
    repeat (3) @(negedge clk);
    chk("R6 irq_n held low", int'(irq_n), 0);
    read_chk(gen(1, 0), "R3 R5 path1");
    chk("R6 irq_n released", int'(irq_n), 1);
    for (int p = 1; p < 4; p++) read_chk(gen(1, p), "R5 path order");
    read_chk(gen(1, 0), "R8 wrap");
  endtask

  task automatic t_two_bank_b;
    write_cfg(4'b0101);
    run_seq(2, 2, 1'b0, 1'b0, 4'h0);
    read_chk(gen(2, 4), "R2 bank B path1");
    read_chk(gen(2, 5), "R2 bank B path2");
    read_chk(gen(2, 4), "R8 wrap two");
  endtask

  task automatic t_restart;
    run_seq(2, 3, 1'b0, 1'b0, 4'h0);
    read_chk(gen(3, 4), "R5 first");
    run_seq(2, 4, 1'b0, 1'b0, 4'h0);
    read_chk(gen(4, 4), "R7 pointer restart");
  endtask

  task automatic t_start_while_busy;
    write_cfg(4'b0000);
    run_seq(1, 5, 1'b1, 1'b0, 4'h0);
    read_chk(gen(5, 0), "R9 result kept");
    read_chk(gen(5, 0), "R8 wrap single");
  endtask

  task automatic t_power_down;
    write_cfg(4'b1011);
    @(negedge clk); start = 1'b1;
    repeat (80) @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 irq_n", int'(irq_n), 1);
    write_cfg(4'b0011);
    repeat (4) @(negedge clk);
    chk("R3 level no launch", int'(busy), 0);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_cfg_mid;
    write_cfg(4'b0001);
    run_seq(2, 6, 1'b0, 1'b1, 4'b0111);
    read_chk(gen(6, 0), "R11 path1");
    read_chk(gen(6, 1), "R11 path2");
    read_chk(gen(6, 0), "R11 wrap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_four_bank_a();
    t_two_bank_b();
    t_restart();
    t_start_while_busy();
    t_power_down();
    t_cfg_mid();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule